// File: doc/BRIEF.md
# Sync Activity Monitor

This block watches four synchronisation signals of a video input path and reports, for each one, whether it is currently toggling. The four signals are:

- the separate horizontal sync,
- the separate vertical sync,
- the vertical sync recovered by a composite-sync slicer,
- the sliced sync-on-green output.

A signal is judged alive when it has shown a transition, of either polarity, within a programmable window counted in system clocks. When the window runs out with no transition, the signal is judged dead.

Every time a signal's alive/dead verdict flips, in either direction, a sticky pending flag for that signal is set. Each flag is gated by its own enable bit onto a single interrupt line. One shared clear input wipes all four flags at once.

The inputs are asynchronous to the system clock. Each one goes through a two-stage synchroniser before its transitions are detected.

Top module: `sync_activity_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `active`, `pending` and `irq` are all zero.
- R2: Bit positions in `sync_in`, `active`, `irq_en` and `pending` are fixed: bit 0 is the separate hsync, bit 1 the separate vsync, bit 2 the composite-slicer vsync and bit 3 the sync-on-green output. A transition of either polarity on an input sets its `active` bit within 4 clocks.
- R3: With `timeout_cfg` = T, an `active` bit remains 1 for at least T-4 clocks after the last input transition of its source. It returns to 0 no later than T+6 clocks after that transition.
- R4: Every change of an `active` bit, 0 to 1 or 1 to 0, sets the matching `pending` bit within 3 clocks. This happens whatever the value of `irq_en`.
- R5: A `pending` bit, once set, stays 1 until `clr_pend` is sampled high on a clock edge. That edge clears all four bits together.
- R6: `irq` is 1 exactly when some bit is 1 in both `pending` and `irq_en`. A source whose enable bit is 0 cannot raise `irq`.
- R7: The sources are independent. Activity on one input never changes the `active` or `pending` bit of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 4 | Asynchronous sync inputs (bit map in R2) |
| timeout_cfg | input | TMO_W | Inactivity window in clocks |
| irq_en | input | 4 | Per-source interrupt enables, 1 = enabled |
| clr_pend | input | 1 | Clears all pending bits when high at a clock edge |
| active | output | 4 | Activity status per source, 1 = active |
| pending | output | 4 | Sticky change flags, 1 = interrupt waiting |
| irq | output | 1 | OR of the enabled pending bits |

## Verification
The bench targets the timeout boundary. It samples the status just inside and just outside the window, so a counter that is off by a large margin, or one that fails to restart on a transition, leaves the source alive too long or drops it too early.

It also checks the falling direction separately from the rising one. A design that flags only activations would leave `pending` clear after a timeout.

Masking is checked with a pending flag present and its enable low; a missing AND would assert `irq` there. The randomised rounds mix sources, enables and clears, which exposes crosstalk between channels and flags that clear without `clr_pend`.

// File: rtl/sam_pkg.sv
package sam_pkg;

    localparam int NUM_SRC = 4;

    typedef enum logic [1:0] {
        SRC_HSYNC  = 2'd0,
        SRC_VSYNC  = 2'd1,
        SRC_CS_VS  = 2'd2,
        SRC_SOG    = 2'd3
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Per-source view produced by the front end
    typedef struct packed {
        logic level;
        logic toggled;
    } sync_view_t;

    function automatic logic any_enabled(input src_vec_t flags, input src_vec_t en);
        return |(flags & en);
    endfunction

endpackage

// File: rtl/sam_sync.sv
module sam_sync
    import sam_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   raw_in,
    output sync_view_t view [NUM_SRC]
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ch
        logic meta_q, stab_q, hist_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                hist_q <= 1'b0;
            end else begin
                meta_q <= raw_in[g];
                stab_q <= meta_q;
                hist_q <= stab_q;
            end
        end

        always_comb begin
            view[g].level   = stab_q;
            view[g].toggled = stab_q ^ hist_q;
        end
    end

endmodule

// File: rtl/sam_tracker.sv
module sam_tracker #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             toggled,
    input  logic [TMO_W-1:0] window,
    output logic             alive
);

    logic [TMO_W-1:0] idle_cnt;
    logic [TMO_W:0]   next_cnt;
    logic             expire;

    always_comb begin
        next_cnt = {1'b0, idle_cnt} + 1'b1;
        expire   = next_cnt >= {1'b0, window};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            alive    <= 1'b0;
        end else if (toggled) begin
            idle_cnt <= '0;
            alive    <= 1'b1;
        end else if (alive) begin
            if (expire) begin
                alive <= 1'b0;
            end else begin
                idle_cnt <= next_cnt[TMO_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sam_pend.sv
module sam_pend
    import sam_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t status,
    input  src_vec_t en,
    input  logic     clr,
    output src_vec_t flags,
    output src_vec_t changed,
    output logic     irq
);

    src_vec_t status_q;

    assign changed = status ^ status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            flags    <= '0;
        end else begin
            status_q <= status;
            // a change seen in the clearing cycle survives the clear
            flags    <= (clr ? '0 : flags) | changed;
        end
    end

    assign irq = any_enabled(flags, en);

endmodule

// File: rtl/sync_activity_monitor.sv
module sync_activity_monitor
    import sam_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       sync_in,
    input  logic [TMO_W-1:0] timeout_cfg,
    input  logic [3:0]       irq_en,
    input  logic             clr_pend,
    output logic [3:0]       active,
    output logic [3:0]       pending,
    output logic             irq
);

    sync_view_t view [NUM_SRC];
    src_vec_t   edge_vec;
    src_vec_t   alive_vec;
    src_vec_t   chg_vec;

    sam_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (sync_in),
        .view   (view)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_trk
        assign edge_vec[g] = view[g].toggled;

        sam_tracker #(.TMO_W(TMO_W)) u_trk (
            .clk     (clk),
            .rst     (rst),
            .toggled (edge_vec[g]),
            .window  (timeout_cfg),
            .alive   (alive_vec[g])
        );
    end

    sam_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .status  (alive_vec),
        .en      (irq_en),
        .clr     (clr_pend),
        .flags   (pending),
        .changed (chg_vec),
        .irq     (irq)
    );

    assign active = alive_vec;

endmodule

// File: rtl/sam_chk.sv
module sam_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] edge_vec,
    input logic [3:0] active,
    input logic [3:0] pending,
    input logic [3:0] irq_en,
    input logic       clr_pend,
    input logic       irq
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (active == 4'd0 && pending == 4'd0 && !irq));

    // R6
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 4'd0) |-> !irq);

    for (genvar g = 0; g < 4; g++) begin : g_bit
        // R2
        rise_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(active[g]) |-> $past(edge_vec[g]));

        // R5
        hold_until_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(pending[g]) |-> $past(clr_pend));

        // R4
        set_on_change_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pending[g]) |-> ($past(active[g]) != $past(active[g], 2)));
    end

endmodule

bind sync_activity_monitor sam_chk u_sam_chk (
    .clk      (clk),
    .rst      (rst),
    .edge_vec (edge_vec),
    .active   (active),
    .pending  (pending),
    .irq_en   (irq_en),
    .clr_pend (clr_pend),
    .irq      (irq)
);

// File: tb/sync_activity_monitor_bench.sv
module sync_activity_monitor_bench;

    localparam int TMO_W = 16;
    localparam int T     = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       sync_in = '0;
    logic [TMO_W-1:0] timeout_cfg = TMO_W'(T);
    logic [3:0]       irq_en = '0;
    logic             clr_pend = 1'b0;
    logic [3:0]       active;
    logic [3:0]       pending;
    logic             irq;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sync_activity_monitor #(.TMO_W(TMO_W)) u_sync_activity_monitor (
        .clk(clk), .rst(rst), .sync_in(sync_in), .timeout_cfg(timeout_cfg),
        .irq_en(irq_en), .clr_pend(clr_pend),
        .active(active), .pending(pending), .irq(irq)
    );

    function automatic logic exp_irq(input logic [3:0] p, input logic [3:0] e);
        return |(p & e);
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // advance n clocks; inputs change on the falling edge
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr_pend = 1'b1;
        tick(1);
        clr_pend = 1'b0;
        tick(1);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: got hang expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] exp_p;
        logic [3:0] mask;
        logic [3:0] prev_mask;
        void'($urandom(32'd1234));

        tick(3);
        check("R1 active in reset", {4'd0, active}, 8'd0);
        check("R1 pending in reset", {4'd0, pending}, 8'd0);
        rst = 1'b0;
        tick(1);
        check("R1 irq after reset", {7'd0, irq}, 8'd0);

        // R2: single rising transition on source 1 (vsync)
        irq_en = 4'b0000;
        sync_in[1] = 1'b1;
        tick(4);
        check("R2 vsync goes active", {4'd0, active}, 8'b0000_0010);
        check("R4 pending set on rise", {4'd0, pending}, 8'b0000_0010);
        check("R6 masked irq stays low", {7'd0, irq}, 8'd0);
        check("R7 other sources untouched", {4'd0, active & 4'b1101}, 8'd0);

        // R3: window boundary after that transition
        tick(T - 8);
        check("R3 still active inside window", {7'd0, active[1]}, 8'd1);
        tick(10);
        check("R3 inactive after window", {7'd0, active[1]}, 8'd0);
        check("R4 pending still set after fall", {7'd0, pending[1]}, 8'd1);

        pulse_clear();
        check("R5 clear wipes pending", {4'd0, pending}, 8'd0);

        // R2: falling transition on sync-on-green counts too
        sync_in[3] = 1'b1;
        tick(T + 10);
        pulse_clear();
        sync_in[3] = 1'b0;
        tick(4);
        check("R2 falling edge activates", {7'd0, active[3]}, 8'd1);
        check("R4 pending on activation", {7'd0, pending[3]}, 8'd1);
        irq_en = 4'b1000;
        tick(1);
        check("R6 enabled pending raises irq", {7'd0, irq}, 8'd1);
        tick(T + 10);
        pulse_clear();
        tick(5);
        check("R5 pending stays clear while idle", {4'd0, pending}, 8'd0);

        // R3: a transition restarts the window
        sync_in[0] = ~sync_in[0];
        tick(T - 10);
        sync_in[0] = ~sync_in[0];
        tick(T - 8);
        check("R3 restart keeps source active", {7'd0, active[0]}, 8'd1);
        tick(16);
        check("R3 expires after restart", {7'd0, active[0]}, 8'd0);
        pulse_clear();

        // randomised rounds
        exp_p = '0;
        prev_mask = '0;
        for (int r = 0; r < 60; r++) begin
            mask   = 4'($urandom);
            irq_en = 4'($urandom);
            for (int c = 0; c < 3 * T; c++) begin
                for (int s = 0; s < 4; s++)
                    if (mask[s] && (c % 8) == 2 * s) sync_in[s] = ~sync_in[s];
                tick(1);
            end
            exp_p = exp_p | (mask ^ prev_mask);
            check("R2 R3 R7 random activity", {4'd0, active}, {4'd0, mask});
            check("R4 R5 random pending", {4'd0, pending}, {4'd0, exp_p});
            check("R6 random irq", {7'd0, irq}, {7'd0, exp_irq(exp_p, irq_en)});
            prev_mask = mask;
            if ($urandom_range(1, 0) == 1) begin
                // keep active sources toggling across the clear
                clr_pend = 1'b1;
                for (int s = 0; s < 4; s++)
                    if (mask[s]) sync_in[s] = ~sync_in[s];
                tick(1);
                clr_pend = 1'b0;
                tick(1);
                exp_p = '0;
                check("R5 random clear", {4'd0, pending}, 8'd0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule